// File: doc/BRIEF.md
# Single-Clock Seconds and Minutes Timer

This block keeps elapsed time in seconds and minutes from one fast system clock. A prescaler counts clock cycles and, every `TICK_DIV` cycles, sets a registered one-second strobe. That strobe is the enable of the seconds counter. When the seconds counter goes from 59 to 0, a second registered strobe enables the minutes counter. Every register sits on the same clock edge. No slower clock is derived or gated. The asynchronous reset is only used to set the power-on state. Every wrap to zero comes from next-state logic, so no counter ever holds an out-of-range value.

A `run` input pauses the whole chain. While `run` is low, the prescaler, both counters and both strobes keep their values. A strobe that was pending when the pause began is therefore used on the first running cycle after the pause, and no second is lost. The default divisor suits a 1 MHz clock. A bench can set it small so that rollovers come quickly.

Top module: `elapsed_timer`

## Requirements
- R1: While `rst_n` is low, `sec_o`, `min_o`, `sec_tick_o` and `min_tick_o` are all zero.
- R2: With `run` held high after reset, `sec_tick_o` is high in the cycle after each group of `TICK_DIV` running cycles. The first pulse follows the `TICK_DIV`-th clock edge.
- R3: `sec_o` increments by one on the clock edge that sees `sec_tick_o` high with `run` high. It goes from 59 to 0, and it changes at no other edge.
- R4: `min_tick_o` goes high on the same edge on which `sec_o` goes from 59 to 0. `min_o` increments on the edge that sees `min_tick_o` high with `run` high, going from 59 to 0, and it changes at no other edge.
- R5: At any clock edge where `run` is low, no output changes, and pending strobes are kept.
- R6: While `run` stays high, each strobe is high for exactly one cycle at a time.
- R7: `sec_o` and `min_o` never exceed 59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the only clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| run | input | 1 | Count enable for the whole chain |
| sec_o | output | 6 | Seconds, 0 to 59 |
| min_o | output | 6 | Minutes, 0 to 59 |
| sec_tick_o | output | 1 | Registered one-second strobe |
| min_tick_o | output | 1 | Registered strobe on seconds wrap |

## Verification
The timer runs with a divisor of 4 in three phases. First `run` is held high through a full hour, so the 59 to 0 wrap of the seconds and the 59:59 to 00:00 rollover both occur. Next, `run` toggles in a fixed irregular pattern. This places pauses on prescaler wraps and on pending strobes, and it shows whether a pause loses or duplicates a second. Last, a reset arrives mid-count, which shows whether every register returns to zero at once. A behavioural model is compared with the outputs on every cycle, so an off-by-one in a strobe or a wrap shows up at the exact cycle where it happens.

// File: rtl/elapsed_timer.sv
module elapsed_timer #(
  parameter int TICK_DIV = 1000000,
  parameter int WRAP_AT  = 60,
  parameter int CW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] sec_o,
  output logic [CW-1:0] min_o,
  output logic          sec_tick_o,
  output logic          min_tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(WRAP_AT - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] sec_q, min_q;
  logic          tick_q, wrap_q;

  wire pre_end = (pre_q == PRE_LAST);
  wire sec_en  = run & tick_q;
  wire min_en  = run & wrap_q;
  wire sec_end = (sec_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= 1'b0;
    end else if (run) begin
      pre_q  <= pre_end ? '0 : pre_q + 1'b1;
      tick_q <= pre_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      wrap_q <= 1'b0;
    end else if (run) begin
      if (sec_en) sec_q <= sec_end ? '0 : sec_q + 1'b1;
      wrap_q <= sec_en & sec_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      min_q <= '0;
    else if (min_en) min_q <= (min_q == CNT_LAST) ? '0 : min_q + 1'b1;
  end

  assign sec_o      = sec_q;
  assign min_o      = min_q;
  assign sec_tick_o = tick_q;
  assign min_tick_o = wrap_q;

  initial begin
    if (TICK_DIV < 2) $error("TICK_DIV must be at least 2");
  end

  p_sec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q < CW'(WRAP_AT));
  p_min_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    min_q < CW'(WRAP_AT));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(sec_q) && $stable(min_q) && $stable(tick_q) && $stable(wrap_q) && $stable(pre_q)));
  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && run) |=> (sec_q == (($past(sec_q) == CNT_LAST) ? '0 : $past(sec_q) + 1'b1)));
  p_sec_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_q && run) |=> $stable(sec_q));
  p_min_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap_q && run) |=> $stable(min_q));
  p_wrap_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_q) |-> (sec_q == '0 && $past(sec_q) == CNT_LAST));
  p_tick_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && run) |=> !tick_q);
  p_wrap_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && run) |=> !wrap_q);
endmodule

// File: tb/elapsed_timer_tb_top.sv
module elapsed_timer_tb_top;
  localparam int DIV = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [5:0] sec_o, min_o;
  logic sec_tick_o, min_tick_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  elapsed_timer #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sec_o(sec_o), .min_o(min_o),
    .sec_tick_o(sec_tick_o), .min_tick_o(min_tick_o)
  );

  int m_pre, m_sec, m_min;
  bit m_tick, m_wrap;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_sec = 0; m_min = 0; m_tick = 0; m_wrap = 0;
    end else if (run) begin
      bit t, w;
      t = (m_pre == DIV - 1);
      m_pre = (m_pre + 1) % DIV;
      w = 0;
      if (m_tick) begin
        w = (m_sec == 59);
        m_sec = (m_sec + 1) % 60;
      end
      if (m_wrap) m_min = (m_min + 1) % 60;
      m_tick = t;
      m_wrap = w;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int  prev_sec, prev_min, prev_st, prev_mt;
  bit  prev_run;
  int  st_len, mt_len;
  bit  saw_top, saw_roll;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 sec", sec_o, m_sec);
      chk("R4 min", min_o, m_min);
      chk("R2 sec_tick", sec_tick_o, m_tick);
      chk("R4 min_tick", min_tick_o, m_wrap);
      if (sec_o > 59 || min_o > 59) chk("R7 range", 1, 0);
      if (!prev_run) begin
        chk("R5 hold sec", sec_o, prev_sec);
        chk("R5 hold min", min_o, prev_min);
        chk("R5 hold tick", sec_tick_o, prev_st);
        chk("R5 hold wrap", min_tick_o, prev_mt);
      end
      if (prev_run) begin
        st_len = sec_tick_o ? st_len + 1 : 0;
        mt_len = min_tick_o ? mt_len + 1 : 0;
        if (st_len > 1) chk("R6 sec_tick width", st_len, 1);
        if (mt_len > 1) chk("R6 min_tick width", mt_len, 1);
      end else begin
        st_len = 0; mt_len = 0;
      end
      if (sec_o == 59 && min_o == 59) saw_top = 1;
      if (saw_top && sec_o == 0 && min_o == 0) saw_roll = 1;
    end
    prev_sec = sec_o; prev_min = min_o;
    prev_st = sec_tick_o; prev_mt = min_tick_o;
    prev_run = run;
  end

  initial begin
    #1;
    chk("R1 sec in reset", sec_o, 0);
    chk("R1 min in reset", min_o, 0);
    chk("R1 ticks in reset", {sec_tick_o, min_tick_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (DIV) @(negedge clk);
    chk("R2 first tick after DIV edges", sec_tick_o, 1);
    repeat (DIV * 3600 + 40) @(negedge clk);
    chk("R4 rollover 59:59 to 00:00 seen", saw_roll, 1);
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      run = ((i % 7) != 3) && ((i % 11) != 5) && ((i / 50) % 9 != 4);
    end
    @(negedge clk);
    run = 1'b1;
    repeat (137) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset mid-run sec", sec_o, 0);
    chk("R1 async reset mid-run min", min_o, 0);
    chk("R1 async reset mid-run ticks", {sec_tick_o, min_tick_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (DIV * 70) @(negedge clk);
    chk("R3 seconds after restart", sec_o, m_sec);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule